// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm Interrupt

This block is a memory-mapped real-time clock. It keeps a 32-bit count of seconds. The count advances by one on every clock cycle where the one-second tick input is high and counting is enabled. Software sees the block through a simple word-addressed register bus. Reads are combinational from the presented address. A write is taken on the rising clock edge where both select and write are high.

Software can preset the count through a write-only register and read the live count at another address. It can program an alarm value. When the count takes on the alarm value, a sticky raw flag is set. A mask register decides whether that flag reaches the single interrupt output. Writing a one to the acknowledge register clears the flag. Eight read-only identification bytes sit at the top of the 4 KB window.

Top module: `secrtc_top`

## Requirements
- R1: After reset the count, alarm, enable, mask and raw flag are all zero, and `irq_o` is low.
- R2: Offset 0x0C bit 0 is the run enable, which can be written and read back. The count at offset 0x00 rises by one at each edge where the tick input is high and the enable is set. Otherwise the count holds.
- R3: The count wraps from 0xFFFFFFFF to 0x00000000.
- R4: A write to offset 0x08 sets the count to the written value at that edge. This takes priority over a tick in the same cycle. Offset 0x08 reads as zero, and writes to offset 0x00 are ignored.
- R5: Offset 0x04 holds the 32-bit alarm value and can be read and written. Raw status bit 0 at offset 0x14 sets at the edge where the count takes on the alarm value, either by a tick or by a preset. Writing an alarm value equal to the current, unchanging count does not set the flag.
- R6: The raw flag stays set until a write to offset 0x1C with bit 0 = 1 clears it. A write there with bit 0 = 0 has no effect. Offset 0x1C reads as zero.
- R7: If the count reaches the alarm in the same cycle as a clear write, the raw flag ends up set.
- R8: Offset 0x10 bit 0 is the interrupt mask, which can be read and written; 1 passes the flag and 0 blocks it. Bit 0 of offset 0x18 reads as raw AND mask, and `irq_o` equals that value.
- R9: Offsets 0x20 through 0xFDC, and any address with bits 1:0 not zero, read as zero and ignore writes.
- R10: Offset 0xFE0 + 4*k, for k = 0..7, reads byte k of parameter `ID_BYTES` (bits 8k+7:8k), zero-extended. Writes to these offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second tick, sampled each cycle |
| bus_sel_i | input | 1 | Bus access select |
| bus_wr_i | input | 1 | Write qualifier |
| bus_addr_i | input | AW (12) | Byte address within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the presented address |
| irq_o | output | 1 | Masked alarm interrupt |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a new alarm hit. Only that case shows whether set wins over clear.

The bench first sets the flag by presetting the count onto the alarm value. It then presets the count one below the alarm. Finally, on a single falling edge, it raises the tick and issues the acknowledge write together, so that both act at the same rising edge. The flag must still read as set afterwards.

A second case checks that rewriting the alarm to equal a stopped count does not set the flag. Only a change of the count can set it.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;

    // word indices of the register slots (byte offset / 4)
    localparam int unsigned W_COUNT  = 0;
    localparam int unsigned W_ALARM  = 1;
    localparam int unsigned W_PRESET = 2;
    localparam int unsigned W_CTRL   = 3;
    localparam int unsigned W_MASK   = 4;
    localparam int unsigned W_RAW    = 5;
    localparam int unsigned W_MSKST  = 6;
    localparam int unsigned W_ACK    = 7;
    // identification bytes occupy the last eight words of a 4 KB window
    localparam int unsigned W_ID_BASE = 1016;
    localparam int unsigned ID_COUNT  = 8;

    typedef struct packed {
        logic alarm_we;
        logic preset_we;
        logic ctrl_we;
        logic mask_we;
        logic ack_we;
    } wr_strobe_t;

endpackage

// File: rtl/secrtc_decode.sv
module secrtc_decode #(
    parameter int unsigned AW = 12,
    localparam int unsigned WORD_W = AW - 2
) (
    input  logic                    sel_i,
    input  logic                    wr_i,
    input  logic [AW-1:0]           addr_i,
    output logic [WORD_W-1:0]       word_o,
    output logic                    aligned_o,
    output secrtc_pkg::wr_strobe_t  stb_o
);
    import secrtc_pkg::*;

    logic wr_ok;

    always_comb begin
        word_o    = addr_i[AW-1:2];
        aligned_o = (addr_i[1:0] == 2'b00);
        wr_ok     = sel_i && wr_i && aligned_o;
        stb_o.alarm_we  = wr_ok && (word_o == WORD_W'(W_ALARM));
        stb_o.preset_we = wr_ok && (word_o == WORD_W'(W_PRESET));
        stb_o.ctrl_we   = wr_ok && (word_o == WORD_W'(W_CTRL));
        stb_o.mask_we   = wr_ok && (word_o == WORD_W'(W_MASK));
        stb_o.ack_we    = wr_ok && (word_o == WORD_W'(W_ACK));
    end

endmodule

// File: rtl/secrtc_counter.sv
module secrtc_counter #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          preset_we_i,
    input  logic          ctrl_we_i,
    input  logic [CW-1:0] wdata_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o,
    output logic          upd_o,
    output logic          en_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          en;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        upd_o = 1'b0;
        if (ctrl_we_i) begin
            st_d.en = wdata_i[0];
        end
        if (preset_we_i) begin
            st_d.cnt = wdata_i;
            upd_o    = 1'b1;
        end else if (st_q.en && tick_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            upd_o    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
    assign en_o      = st_q.en;

endmodule

// File: rtl/secrtc_irq.sv
module secrtc_irq #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alarm_we_i,
    input  logic          mask_we_i,
    input  logic          ack_we_i,
    input  logic [CW-1:0] wdata_i,
    input  logic          upd_i,
    input  logic [CW-1:0] cnt_nxt_i,
    output logic [CW-1:0] alarm_o,
    output logic          mask_o,
    output logic          raw_o
);

    typedef struct packed {
        logic [CW-1:0] alarm;
        logic          mask;
        logic          raw;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    hit;
    logic    clr;

    always_comb begin
        st_d = st_q;
        hit  = upd_i && (cnt_nxt_i == st_q.alarm);
        clr  = ack_we_i && wdata_i[0];
        if (alarm_we_i) begin
            st_d.alarm = wdata_i;
        end
        if (mask_we_i) begin
            st_d.mask = wdata_i[0];
        end
        // a new hit outranks a simultaneous clear
        st_d.raw = (st_q.raw && !clr) || hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_o = st_q.alarm;
    assign mask_o  = st_q.mask;
    assign raw_o   = st_q.raw;

endmodule

// File: rtl/secrtc_top.sv
module secrtc_top #(
    parameter int unsigned AW       = 12,
    parameter int unsigned CW       = 32,
    parameter logic [63:0] ID_BYTES = 64'h0D_F0_B1_05_C7_31_10_24,
    localparam int unsigned WORD_W  = AW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          bus_sel_i,
    input  logic          bus_wr_i,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [CW-1:0] bus_wdata_i,
    output logic [CW-1:0] bus_rdata_o,
    output logic          irq_o
);
    import secrtc_pkg::*;

    localparam int unsigned IDX_W = $clog2(ID_COUNT);

    wr_strobe_t          stb;
    logic [WORD_W-1:0]   word;
    logic                aligned;
    logic [CW-1:0]       cnt_q_w;
    logic [CW-1:0]       cnt_nxt_w;
    logic                upd_w;
    logic                en_w;
    logic [CW-1:0]       alarm_w;
    logic                mask_w;
    logic                raw_w;
    logic [7:0]          id_byte;

    secrtc_decode #(.AW(AW)) u_decode (
        .sel_i     (bus_sel_i),
        .wr_i      (bus_wr_i),
        .addr_i    (bus_addr_i),
        .word_o    (word),
        .aligned_o (aligned),
        .stb_o     (stb)
    );

    secrtc_counter #(.CW(CW)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .preset_we_i (stb.preset_we),
        .ctrl_we_i   (stb.ctrl_we),
        .wdata_i     (bus_wdata_i),
        .cnt_o       (cnt_q_w),
        .cnt_nxt_o   (cnt_nxt_w),
        .upd_o       (upd_w),
        .en_o        (en_w)
    );

    secrtc_irq #(.CW(CW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .alarm_we_i (stb.alarm_we),
        .mask_we_i  (stb.mask_we),
        .ack_we_i   (stb.ack_we),
        .wdata_i    (bus_wdata_i),
        .upd_i      (upd_w),
        .cnt_nxt_i  (cnt_nxt_w),
        .alarm_o    (alarm_w),
        .mask_o     (mask_w),
        .raw_o      (raw_w)
    );

    assign irq_o = raw_w && mask_w;

    // identification byte selected by the low word bits
    always_comb begin
        id_byte = '0;
        for (int k = 0; k < ID_COUNT; k++) begin
            if (word[IDX_W-1:0] == IDX_W'(k)) begin
                id_byte = ID_BYTES[8*k +: 8];
            end
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            if (word == WORD_W'(W_COUNT)) begin
                bus_rdata_o = cnt_q_w;
            end else if (word == WORD_W'(W_ALARM)) begin
                bus_rdata_o = alarm_w;
            end else if (word == WORD_W'(W_CTRL)) begin
                bus_rdata_o = CW'(en_w);
            end else if (word == WORD_W'(W_MASK)) begin
                bus_rdata_o = CW'(mask_w);
            end else if (word == WORD_W'(W_RAW)) begin
                bus_rdata_o = CW'(raw_w);
            end else if (word == WORD_W'(W_MSKST)) begin
                bus_rdata_o = CW'(irq_o);
            end else if (word >= WORD_W'(W_ID_BASE)) begin
                bus_rdata_o = CW'(id_byte);
            end
        end
    end

endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk #(
    parameter int unsigned CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic [CW-1:0] wdata,
    input logic          preset_we,
    input logic          ack_we,
    input logic          en,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] alarm,
    input logic          raw,
    input logic          irq_o
);

    AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        preset_we |=> cnt == $past(wdata)); // R4

    AST_TICK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_we && en && tick_i) |=> cnt == CW'($past(cnt) + 1'b1)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_we && !(en && tick_i)) |=> $stable(cnt)); // R2

    AST_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_we && en && tick_i && cnt == '1) |=> cnt == '0); // R3

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !(ack_we && wdata[0])) |=> raw); // R6

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw) |-> cnt == $past(alarm)); // R5

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> raw); // R8

endmodule

bind secrtc_top secrtc_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wdata     (bus_wdata_i),
    .preset_we (stb.preset_we),
    .ack_we    (stb.ack_we),
    .en        (en_w),
    .cnt       (cnt_q_w),
    .alarm     (alarm_w),
    .raw       (raw_w),
    .irq_o     (irq_o)
);

// File: tb/tb_secrtc_top.sv
`timescale 1ns/1ps
module tb_secrtc_top;

    localparam logic [63:0] TB_ID = 64'h5A_A5_3C_C3_0F_F0_81_7E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [11:0] bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    secrtc_top #(.ID_BYTES(TB_ID)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_sel_i   (bus_sel_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .irq_o       (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 1'b0; bus_wr_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr_i = a;
        #1 d = bus_rdata_o;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v); check("R1 count", v, 0);
        rd(12'h004, v); check("R1 alarm", v, 0);
        rd(12'h00C, v); check("R1 enable", v, 0);
        rd(12'h010, v); check("R1 mask", v, 0);
        rd(12'h014, v); check("R1 raw", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(12'h004, 32'h0000_1000);
        wr(12'h00C, 1);
        rd(12'h00C, v); check("R2 enable readback", v, 1);
        ticks(5);
        rd(12'h000, v); check("R2 five ticks", v, 5);
        repeat (4) @(negedge clk);
        rd(12'h000, v); check("R2 no tick holds", v, 5);
        wr(12'h00C, 0);
        ticks(3);
        rd(12'h000, v); check("R2 disabled holds", v, 5);
    endtask

    task automatic t_preset();
        logic [31:0] v;
        wr(12'h008, 32'h1234_5678);
        rd(12'h000, v); check("R4 preset value", v, 32'h1234_5678);
        rd(12'h008, v); check("R4 preset reads zero", v, 0);
        wr(12'h000, 32'h0);
        rd(12'h000, v); check("R4 count write ignored", v, 32'h1234_5678);
        wr(12'h00C, 1);
        @(negedge clk);
        tick_i = 1'b1; bus_sel_i = 1'b1; bus_wr_i = 1'b1;
        bus_addr_i = 12'h008; bus_wdata_i = 32'd100;
        @(negedge clk);
        tick_i = 1'b0; bus_sel_i = 1'b0; bus_wr_i = 1'b0;
        rd(12'h000, v); check("R4 preset beats tick", v, 100);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(12'h008, 32'hFFFF_FFFE);
        ticks(1);
        rd(12'h000, v); check("R3 at max", v, 32'hFFFF_FFFF);
        ticks(1);
        rd(12'h000, v); check("R3 wrapped", v, 0);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(12'h01C, 1);
        wr(12'h004, 32'd10);
        rd(12'h004, v); check("R5 alarm readback", v, 10);
        wr(12'h008, 32'd7);
        ticks(2);
        rd(12'h014, v); check("R5 no flag before match", v, 0);
        ticks(1);
        rd(12'h014, v); check("R5 flag on tick match", v, 1);
        rd(12'h018, v); check("R8 masked status blocked", v, 0);
        check("R8 irq blocked", {31'b0, irq_o}, 0);
        wr(12'h010, 1);
        rd(12'h010, v); check("R8 mask readback", v, 1);
        rd(12'h018, v); check("R8 masked status", v, 1);
        check("R8 irq passes", {31'b0, irq_o}, 1);
        ticks(1);
        rd(12'h014, v); check("R6 flag sticky", v, 1);
        wr(12'h01C, 0);
        rd(12'h014, v); check("R6 ack bit0=0 no effect", v, 1);
        rd(12'h01C, v); check("R6 ack reads zero", v, 0);
        wr(12'h01C, 1);
        rd(12'h014, v); check("R6 ack clears", v, 0);
        check("R8 irq drops", {31'b0, irq_o}, 0);
        wr(12'h008, 32'd10);
        rd(12'h014, v); check("R5 flag on preset match", v, 1);
        wr(12'h00C, 0);
        wr(12'h008, 32'd40);
        wr(12'h01C, 1);
        wr(12'h004, 32'd40);
        repeat (2) @(negedge clk);
        rd(12'h014, v); check("R5 alarm write onto count no flag", v, 0);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        wr(12'h004, 32'd60);
        wr(12'h00C, 1);
        wr(12'h008, 32'd60);
        wr(12'h008, 32'd59);
        rd(12'h014, v); check("R7 flag preset", v, 1);
        @(negedge clk);
        tick_i = 1'b1; bus_sel_i = 1'b1; bus_wr_i = 1'b1;
        bus_addr_i = 12'h01C; bus_wdata_i = 32'd1;
        @(negedge clk);
        tick_i = 1'b0; bus_sel_i = 1'b0; bus_wr_i = 1'b0;
        rd(12'h000, v); check("R7 count reached alarm", v, 60);
        rd(12'h014, v); check("R7 set wins over clear", v, 1);
        wr(12'h00C, 0);
        wr(12'h01C, 1);
        rd(12'h014, v); check("R7 later clear works", v, 0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h800, 32'hFFFF_FFFF);
        wr(12'hFDC, 32'hFFFF_FFFF);
        wr(12'h006, 32'hFFFF_FFFF);
        rd(12'h020, v); check("R9 reserved 0x020", v, 0);
        rd(12'h800, v); check("R9 reserved 0x800", v, 0);
        rd(12'hFDC, v); check("R9 reserved 0xFDC", v, 0);
        rd(12'h001, v); check("R9 misaligned reads zero", v, 0);
        rd(12'h004, v); check("R9 alarm untouched", v, 60);
        rd(12'h000, v); check("R9 count untouched", v, 60);
        rd(12'h00C, v); check("R9 enable untouched", v, 0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(12'hFE0 + 12'(4 * k), v);
            check($sformatf("R10 id byte %0d", k), v, {24'b0, TB_ID[8*k +: 8]});
        end
        wr(12'hFE0, 32'hFFFF_FFFF);
        rd(12'hFE0, v); check("R10 id write ignored", v, {24'b0, TB_ID[7:0]});
    endtask

    initial begin
        #200000;
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_preset();
        t_wrap();
        t_match();
        t_setwins();
        t_reserved();
        t_id();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

endmodule